// File: doc/BRIEF.md
# Serial Expansion Bus Master

This block is a memory-mapped master for a serial expansion bus that works much like SPI. A processor selects one peripheral and a serial clock rate through a status register. It loads a 32-bit data word and then writes a control word whose go bit launches an immediate transfer of 8, 16, 24 or 32 bits. The transfer can be a read, a write or a full exchange. When the last bit has been clocked, a completion flag in the status register goes high. Software polls that flag, and clears it by writing a one to it.

The chip-select does not end with each transfer. Once the first transfer of a transaction starts, the chip-select stays low until software writes the status register with an empty device field. This lets a command word followed by a data word reach the peripheral as one framed transaction. The serial clock idles low. Data leaves most significant bit first and changes on the falling edge. Received bits are sampled on the rising edge.

Top module: `sexb_master`

## Requirements
- R1: After reset all three registers read zero, every chip-select is high (inactive), and SCLK and MOSI are low.
- R2: Register map and readback:
  - Offset 0 is the status register: device field in bits 9:7, rate code in bits 6:4, completion flag in bit 3, all other bits zero.
  - Offset 12 is the control register: length code in bits 5:4, direction code in bits 3:2, mode in bit 1, busy in bit 0.
  - Offset 16 is the 32-bit data register.
  - Any other offset reads zero.
- R3: A control write with bit 0 = 1 and bit 1 = 0 while idle starts a transfer, and control bit 0 then reads 1 until the transfer ends.
- R4: The completion flag rises exactly 2·N·H clock cycles after the clock edge that accepts the start.
  - N is the bit count.
  - H = HALF_FAST << (5 − rate), where rate codes 0..5 map to 1..32 MHz and codes 6 and 7 act as 5.
- R5: In write direction (code 1), MOSI carries data bits 31 down to 32−N, one per SCLK period, stable at each rising edge. The data register is left unchanged. SCLK makes exactly N rising edges and idles low.
- R6: In read direction (code 0), MOSI stays low. MISO is sampled on each rising SCLK edge, and the first bit received lands in data bit 31. The data register becomes the N received bits left-aligned, with the lower 32−N bits zero.
- R7: Direction codes 2 and 3 exchange: MOSI is driven as in R5 and the data register is captured as in R6.
- R8: Length code L gives N = 8·(L+1) bits; code 3 is 32 bits.
- R9: A status write with bit 3 = 1 clears the completion flag. With bit 3 = 0 the flag is kept.
- R10: Chip-select and device field:
  - The lowest set bit k of the device field selects chip-select k, so 0x100 selects device 1.
  - No chip-select goes low before a transfer starts.
  - The chip-select stays low across later transfers until a status write with a zero device field.
- R11: While a transfer is in progress, writes to the control or data register are ignored.
- R12: A control write with bit 1 (non-immediate mode) set starts nothing: no busy, no completion, no chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 3 | Active-low chip-selects, one per device |

## Verification
Register writes take effect at the accepting clock edge. The bench therefore reads status, control and data in the low phase that follows, without waiting further. The completion flag is due exactly 2·N·H cycles after the start edge. The bench keeps a free-running cycle counter, records it just after the start write, and polls the flag once per clock in the low phase, so the first poll that sees the flag gives the exact latency to compare. Serial results (bits seen on MOSI, the rising-edge count, the captured word and the chip-select levels) are checked only after the flag is seen, when no further SCLK edge can occur.

// File: rtl/sexb_pkg.sv
`timescale 1ns/1ps
package sexb_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 5;
  localparam int unsigned DEV_W = 3;

  localparam logic [AW-1:0] STAT_ADDR = 5'd0;
  localparam logic [AW-1:0] CTRL_ADDR = 5'd12;
  localparam logic [AW-1:0] DATA_ADDR = 5'd16;

  // status field positions
  localparam int unsigned DEV_LSB  = 7;
  localparam int unsigned RATE_LSB = 4;
  localparam int unsigned DONE_BIT = 3;
  // control field positions
  localparam int unsigned CTL_GO   = 0;
  localparam int unsigned CTL_MODE = 1;
  localparam int unsigned DIR_LSB  = 2;
  localparam int unsigned LEN_LSB  = 4;

  // system cycles per SCLK half period for a rate code
  function automatic int unsigned half_cycles(logic [2:0] rate, int unsigned fast);
    int unsigned r;
    r = (rate > 3'd5) ? 32'd5 : 32'(rate);
    return fast << (5 - r);
  endfunction

  function automatic int unsigned bit_count(logic [1:0] len);
    return 8 * (32'(len) + 1);
  endfunction

  function automatic logic dir_drives(logic [1:0] d);
    return d != 2'd0;
  endfunction

  function automatic logic dir_captures(logic [1:0] d);
    return d != 2'd1;
  endfunction

  function automatic logic [DW-1:0] align_rx(logic [DW-1:0] rx, logic [1:0] len);
    return rx << (DW - bit_count(len));
  endfunction

  function automatic logic [DEV_W-1:0] lowest_bit(logic [DEV_W-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/sexb_clkdiv.sv
`timescale 1ns/1ps
module sexb_clkdiv
  import sexb_pkg::*;
#(
  parameter int unsigned HALF_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int unsigned CW = $clog2(HALF_FAST * 32) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] reload_d;

  assign reload_d = CW'(half_cycles(rate, HALF_FAST) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= reload_d;
      reload_q <= reload_d;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);

  // R4: a tick always restarts a full half period
  a_r4_half_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load |=> cnt_q == reload_q);
endmodule

// File: rtl/sexb_shift.sv
`timescale 1ns/1ps
module sexb_shift
  import sexb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    dir,
  input  logic [1:0]    len,
  input  logic [DW-1:0] tx_word,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  output logic          finish,
  output logic          capture,
  output logic [DW-1:0] rx_word
);
  logic          busy_q, sclk_q;
  logic [DW-1:0] tx_q, rx_q;
  logic [5:0]    left_q;
  logic [1:0]    dir_q, len_q;
  logic          rise_ev, fall_ev;

  assign rise_ev = busy_q && tick && !sclk_q;
  assign fall_ev = busy_q && tick && sclk_q;
  assign finish  = fall_ev && (left_q == 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      dir_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      tx_q   <= tx_word;
      rx_q   <= '0;
      left_q <= 6'(bit_count(len));
      dir_q  <= dir;
      len_q  <= len;
    end else if (busy_q && tick) begin
      sclk_q <= ~sclk_q;
      if (rise_ev) begin
        rx_q <= {rx_q[DW-2:0], miso};
      end
      if (fall_ev) begin
        tx_q   <= tx_q << 1;
        left_q <= left_q - 1'b1;
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q && dir_drives(dir_q) && tx_q[DW-1];
  assign capture = finish && dir_captures(dir_q);
  assign rx_word = align_rx(rx_q, len_q);

  // R3: an accepted start makes the engine busy on the next cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  // R11: the register file never launches into a running engine
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R5: serial clock parked low whenever idle
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  // R8: the last falling edge ends the transfer
  a_r8_finish_ends: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q && !sclk_q);
endmodule

// File: rtl/sexb_regs.sv
`timescale 1ns/1ps
module sexb_regs
  import sexb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic             finish,
  input  logic             capture,
  input  logic [DW-1:0]    rx_word,
  output logic [DW-1:0]    rdata,
  output logic             start,
  output logic [2:0]       rate,
  output logic [1:0]       dir,
  output logic [1:0]       len,
  output logic [DW-1:0]    tx_word,
  output logic [DEV_W-1:0] cs_n
);
  logic [DEV_W-1:0] dev_q;
  logic [2:0]       rate_q;
  logic             done_q, held_q, mode_q;
  logic [1:0]       dir_q, len_q;
  logic [DW-1:0]    data_q;
  logic             stat_wr, ctrl_wr, data_wr;
  logic [DEV_W-1:0] dev_in;
  logic             unused_bits;

  assign stat_wr = wr_en && (addr == STAT_ADDR);
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
  assign data_wr = wr_en && (addr == DATA_ADDR);
  assign dev_in  = wdata[DEV_LSB +: DEV_W];
  assign start   = ctrl_wr && !busy && wdata[CTL_GO] && !wdata[CTL_MODE];
  assign unused_bits = ^{wdata[DW-1:DEV_LSB+DEV_W], wdata[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      rate_q <= '0;
      done_q <= 1'b0;
      held_q <= 1'b0;
      mode_q <= 1'b0;
      dir_q  <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else begin
      if (stat_wr) begin
        dev_q  <= dev_in;
        rate_q <= wdata[RATE_LSB +: 3];
        if (wdata[DONE_BIT]) done_q <= 1'b0;
        if (dev_in == '0)    held_q <= 1'b0;
      end
      if (ctrl_wr && !busy) begin
        mode_q <= wdata[CTL_MODE];
        dir_q  <= wdata[DIR_LSB +: 2];
        len_q  <= wdata[LEN_LSB +: 2];
      end
      if (start) held_q <= 1'b1;
      if (data_wr && !busy) data_q <= wdata;
      if (capture)          data_q <= rx_word;
      if (finish)           done_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      STAT_ADDR: rdata = {22'd0, dev_q, rate_q, done_q, 3'd0};
      CTRL_ADDR: rdata = {26'd0, len_q, dir_q, mode_q, busy};
      DATA_ADDR: rdata = data_q;
      default:   rdata = '0;
    endcase
  end

  // launch parameters come from the write that starts the transfer
  assign rate    = rate_q;
  assign dir     = wdata[DIR_LSB +: 2];
  assign len     = wdata[LEN_LSB +: 2];
  assign tx_word = data_q;
  assign cs_n    = ~(held_q ? lowest_bit(dev_q) : '0);

  // R9: completion always raises the flag
  a_r9_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q);
  // R10: at most one chip-select low
  a_r10_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R10: a started transfer with a device chosen drives a select
  a_r10_cs_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && (dev_q != '0) |=> cs_n != '1);
  // R11: control fields frozen while busy
  a_r11_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && busy |=> $stable(len_q) && $stable(dir_q));
endmodule

// File: rtl/sexb_master.sv
`timescale 1ns/1ps
module sexb_master
  import sexb_pkg::*;
#(
  parameter int unsigned HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  cs_n
);
  logic          start, busy, tick, finish, capture;
  logic [2:0]    rate;
  logic [1:0]    dir, len;
  logic [DW-1:0] tx_word, rx_word;

  sexb_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .busy    (busy),
    .finish  (finish),
    .capture (capture),
    .rx_word (rx_word),
    .rdata   (bus_rdata),
    .start   (start),
    .rate    (rate),
    .dir     (dir),
    .len     (len),
    .tx_word (tx_word),
    .cs_n    (cs_n)
  );

  sexb_clkdiv #(.HALF_FAST(HALF_FAST)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .run   (busy),
    .rate  (rate),
    .tick  (tick)
  );

  sexb_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dir     (dir),
    .len     (len),
    .tx_word (tx_word),
    .tick    (tick),
    .miso    (miso),
    .busy    (busy),
    .sclk    (sclk),
    .mosi    (mosi),
    .finish  (finish),
    .capture (capture),
    .rx_word (rx_word)
  );

  // R12: a non-immediate control write from idle leaves the engine idle
  a_r12_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == CTRL_ADDR) && bus_wdata[CTL_MODE] && !busy |=> !busy);
endmodule

// File: tb/tb_sexb_master.sv
`timescale 1ns/1ps
module tb_sexb_master;
  localparam int HALF_FAST = 2;
  localparam logic [4:0] A_STAT = 5'd0, A_CTRL = 5'd12, A_DATA = 5'd16;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [2:0]  cs_n;

  int checks = 0, fails = 0, cyc = 0, t0 = 0;
  logic [31:0] sword = '0, mcap = '0;
  int sidx = 0, rises = 0;
  logic [2:0]  cur_dev, cur_rate;
  logic [1:0]  cur_dir, cur_len;
  logic [31:0] cur_tx, cur_sw;

  sexb_master #(.HALF_FAST(HALF_FAST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // peripheral model: shifts sword out MSB first, collects MOSI
  assign miso = (sidx < 32) ? sword[31 - sidx] : 1'b0;
  always @(negedge sclk) sidx = sidx + 1;
  always @(posedge sclk) begin
    mcap  = {mcap[30:0], mosi};
    rises = rises + 1;
  end

  function automatic int exp_cycles(logic [2:0] rate, logic [1:0] len);
    int r = (rate > 5) ? 5 : int'(rate);
    return 2 * (8 * (int'(len) + 1)) * (HALF_FAST << (5 - r));
  endfunction
  function automatic logic [31:0] top_mask(int n);
    return ~(32'hFFFF_FFFF >> n);
  endfunction
  function automatic logic [2:0] low_sel(logic [2:0] d);
    for (int k = 0; k < 3; k++) if (d[k]) return 3'(1 << k);
    return 3'd0;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic launch(input logic [2:0] dev, input logic [2:0] rate,
                        input logic [1:0] dir, input logic [1:0] len,
                        input logic [31:0] tx, input logic [31:0] sw);
    logic [31:0] r;
    cur_dev = dev; cur_rate = rate; cur_dir = dir; cur_len = len;
    cur_tx = tx; cur_sw = sw;
    bus_write(A_STAT, {22'd0, dev, rate, 1'b1, 3'd0});
    bus_write(A_DATA, tx);
    sword = sw; sidx = 0; mcap = '0; rises = 0;
    bus_write(A_CTRL, {26'd0, len, dir, 1'b0, 1'b1});
    t0 = cyc;
    bus_read(A_CTRL, r);
    chk("R3 busy bit after start", {31'd0, r[0]}, 32'd1);
  endtask

  task automatic finish_xfer();
    logic [31:0] r, exp_mosi, exp_data;
    int n;
    n = 8 * (int'(cur_len) + 1);
    forever begin
      @(negedge clk);
      bus_read(A_STAT, r);
      if (r[3]) break;
      if (cyc - t0 > 20000) break;
    end
    chk("R4 cycles from start to done", 32'(cyc - t0), 32'(exp_cycles(cur_rate, cur_len)));
    chk("R8 SCLK rising edges", 32'(rises), 32'(n));
    exp_mosi = (cur_dir == 2'd0) ? 32'd0 : (cur_tx >> (32 - n));
    chk((cur_dir == 2'd0) ? "R6 MOSI low in read" : "R5 MOSI bit order", mcap, exp_mosi);
    exp_data = (cur_dir == 2'd1) ? cur_tx : (cur_sw & top_mask(n));
    bus_read(A_DATA, r);
    chk((cur_dir == 2'd1) ? "R5 data kept on write" :
        (cur_dir == 2'd0) ? "R6 read capture" : "R7 exchange capture", r, exp_data);
    bus_read(A_CTRL, r);
    chk("R3 busy clears", {31'd0, r[0]}, 32'd0);
    chk("R10 chip-select held", {29'd0, cs_n}, {29'd0, ~low_sel(cur_dev)});
    chk("R5 SCLK idle low", {31'd0, sclk}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=hung expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EB1_0C27));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_STAT, r); chk("R1 status at reset", r, 32'd0);
    bus_read(A_CTRL, r); chk("R1 control at reset", r, 32'd0);
    bus_read(A_DATA, r); chk("R1 data at reset", r, 32'd0);
    chk("R1 pins at reset", {27'd0, cs_n, sclk, mosi}, {27'd0, 3'b111, 2'b00});

    // R2 readback and field masking
    bus_write(A_STAT, 32'hFFFF_FC00 | 32'h2B0);
    bus_read(A_STAT, r); chk("R2 status readback", r, 32'h2B0);
    chk("R10 no select before start", {29'd0, cs_n}, 32'd7);
    bus_write(A_DATA, 32'h1234_5678);
    bus_read(A_DATA, r); chk("R2 data readback", r, 32'h1234_5678);
    bus_write(A_CTRL, 32'h24);
    bus_read(A_CTRL, r); chk("R2 control readback", r, 32'h24);
    bus_read(5'd4, r); chk("R2 unmapped offset", r, 32'd0);

    // R12 non-immediate mode
    bus_write(A_STAT, 32'h0000_0108);
    rises = 0;
    bus_write(A_CTRL, 32'h37);
    repeat (10) @(negedge clk);
    bus_read(A_STAT, r); chk("R12 no completion", {31'd0, r[3]}, 32'd0);
    bus_read(A_CTRL, r); chk("R12 not busy", {31'd0, r[0]}, 32'd0);
    chk("R12 no select, no clock", {29'd0, cs_n}, 32'd7);
    chk("R12 no SCLK edges", 32'(rises), 32'd0);

    // R6/R10 read of 8 bits at slowest rate, then command+data transaction
    launch(3'b010, 3'd0, 2'd0, 2'd0, 32'hFFFF_FFFF, 32'hC3A5_1E77);
    finish_xfer();
    // R9: write without bit 3 keeps the flag
    bus_write(A_STAT, {22'd0, 3'b010, 3'd3, 1'b0, 3'd0});
    bus_read(A_STAT, r); chk("R9 flag kept", {31'd0, r[3]}, 32'd1);
    bus_write(A_STAT, {22'd0, 3'b010, 3'd3, 1'b1, 3'd0});
    bus_read(A_STAT, r); chk("R9 flag cleared", {31'd0, r[3]}, 32'd0);
    chk("R10 select kept over status rewrite", {29'd0, cs_n}, 32'h5);
    launch(3'b010, 3'd3, 2'd1, 2'd3, 32'h8000_0400, 32'h0);
    finish_xfer();
    bus_write(A_STAT, 32'd0);
    chk("R10 select dropped by zero status", {29'd0, cs_n}, 32'd7);

    // R7 exchange with lowest-bit priority, clamp of rate 7
    launch(3'b110, 3'd7, 2'd2, 2'd1, 32'hA55A_0000, 32'h9ABC_DEF0);
    finish_xfer();
    launch(3'b111, 3'd6, 2'd3, 2'd2, 32'h1357_9BDF, 32'hF0E1_D2C3);
    finish_xfer();

    // R11 writes during a transfer are ignored
    launch(3'b001, 3'd5, 2'd1, 2'd3, 32'hA5C3_0F96, 32'h0);
    @(negedge clk);
    bus_write(A_CTRL, 32'h01);
    bus_write(A_DATA, 32'hDEAD_BEEF);
    bus_read(A_CTRL, r); chk("R11 control unchanged while busy", r, 32'h35);
    finish_xfer();
    bus_write(A_STAT, 32'd0);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      logic [2:0] d, rt;
      d  = 3'($urandom_range(1, 7));
      rt = 3'($urandom_range(2, 7));
      launch(d, rt, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             $urandom, $urandom);
      finish_xfer();
      if ($urandom_range(0, 1) == 1) begin
        bus_write(A_STAT, 32'd0);
        chk("R10 select released", {29'd0, cs_n}, 32'd7);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule